// File: doc/BRIEF.md
# Packet Buffer Byte Window

This block gives a byte-wide register bus a window into a packet buffer memory split into several equal buffers. A 16-bit pointer register, loaded one byte at a time, chooses the buffer and the byte offset inside it. Four consecutive data-port addresses then reach the memory. Depending on a pointer flag, either every data access steps the offset forward by one for streaming, or the four port addresses reach the pointed byte and the three after it without moving the pointer.

The buffer number comes from one of two inputs that the surrounding logic drives: the current packet-number register or the head of the receive queue. A high bit of the pointer picks between them. The memory and the read-data multiplexing are inside the block. Read data is registered and appears in the cycle after the read strobe. The offset field is `OFS_W` bits wide, and the buffer size is 2^`OFS_W` bytes. The default is 9, which keeps elaboration small. Setting it to 11 gives 2048-byte buffers. The flags keep their positions at bits 15 and 14.

Top module: `pktbuf_window`

## Requirements
- R1: While reset is asserted and after it is released, the pointer holds 0 and `bus_rdata` is 0 until a read is made.
- R2: A write to address 6 replaces pointer bits [7:0] and a write to address 7 replaces bits [15:8]. The other byte keeps its value.
- R3: A read of address 6 returns pointer bits [7:0], and a read of address 7 returns bits [15:8] ANDed with 0xF7, so bit 3 of that byte reads 0. Data appears in the cycle after the read strobe.
- R4: When pointer bit 15 is 1, data accesses use the buffer given by `rxq_head`. When it is 0, they use `pkt_num`. Both inputs are sampled in the access cycle.
- R5: When pointer bit 14 is 1, a data access (read or write at addresses 8 to 11) uses the current offset. The offset field, pointer bits [OFS_W-1:0], then increments by one and wraps to 0 inside that field. Pointer bits [15:OFS_W] keep their values.
- R6: When pointer bit 14 is 0, a data access at address 8+k (k = 0..3, taken from the low two address bits) targets offset (pointer offset + k) modulo 2^OFS_W, and the pointer is not changed.
- R7: A byte written through the data port is stored at the targeted location and is returned by a later read of the same location. A cycle never carries both a read strobe and a write strobe.
- R8: `bus_rdata` is 0 in any cycle that does not follow a read. A read of any address other than 6, 7 and 8 to 11 returns 0.
- R9: Auto-increment accesses on consecutive cycles each use the offset left by the previous access, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Byte register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| pkt_num | input | $clog2(NUM_BUFS) | Buffer number from the packet-number register |
| rxq_head | input | $clog2(NUM_BUFS) | Buffer number at the head of the receive queue |

## Verification
In one clock edge, a data access both reads or writes the memory and advances the pointer that formed its address. The two must not interfere: the byte must come from the old offset and the pointer must step exactly once. The bench provokes this with back-to-back auto-increment bursts, and with single accesses at the last offset of a buffer, where the step wraps while flag bits above the field are set. It judges both effects from the data returned and from the pointer read back afterwards, against a model that applies the access first and the step after.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  localparam int PTR_W   = 16;
  localparam int SEL_BIT = 15;
  localparam int INC_BIT = 14;
  localparam logic [7:0] HI_RD_MASK = 8'hF7;
  localparam logic [3:0] A_PTR_LO   = 4'd6;
  localparam logic [3:0] A_PTR_HI   = 4'd7;
  localparam logic [1:0] DATA_PAGE  = 2'b10;

  typedef struct packed {
    logic ptr_lo_wr;
    logic ptr_hi_wr;
    logic ptr_lo_rd;
    logic ptr_hi_rd;
    logic dat_wr;
    logic dat_rd;
  } pbw_acc_t;

  typedef enum logic [1:0] {RS_ZERO, RS_MEM, RS_REG} pbw_rsel_t;
endpackage

// File: rtl/pbw_decode.sv
module pbw_decode
  import pbw_pkg::*;
(
  input  logic [3:0] addr,
  input  logic       rd,
  input  logic       wr,
  output pbw_acc_t   acc
);
  logic is_data;

  always_comb begin
    is_data       = (addr[3:2] == DATA_PAGE);
    acc.ptr_lo_wr = wr && (addr == A_PTR_LO);
    acc.ptr_hi_wr = wr && (addr == A_PTR_HI);
    acc.ptr_lo_rd = rd && (addr == A_PTR_LO);
    acc.ptr_hi_rd = rd && (addr == A_PTR_HI);
    acc.dat_wr    = wr && is_data;
    acc.dat_rd    = rd && is_data;
  end
endmodule

// File: rtl/pbw_ptr.sv
module pbw_ptr
  import pbw_pkg::*;
#(
  parameter int OFS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pbw_acc_t         acc,
  input  logic [7:0]       wdata,
  output logic [PTR_W-1:0] ptr_q
);
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;
  logic             step;

  always_comb begin
    step   = (acc.dat_wr || acc.dat_rd) && ptr_q[INC_BIT];
    ptr_en = acc.ptr_lo_wr || acc.ptr_hi_wr || step;
    ptr_d  = ptr_q;
    if (acc.ptr_lo_wr) ptr_d[7:0]  = wdata;
    if (acc.ptr_hi_wr) ptr_d[15:8] = wdata;
    if (step)          ptr_d[OFS_W-1:0] = ptr_q[OFS_W-1:0] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/pbw_addr_gen.sv
module pbw_addr_gen #(
  parameter int OFS_W = 9,
  parameter int BUF_W = 2
) (
  input  logic             sel_rxq,
  input  logic             auto_inc,
  input  logic [OFS_W-1:0] ofs,
  input  logic [1:0]       lane,
  input  logic [BUF_W-1:0] pkt_num,
  input  logic [BUF_W-1:0] rxq_head,
  output logic [BUF_W+OFS_W-1:0] mem_addr
);
  logic [BUF_W-1:0] buf_sel;
  logic [OFS_W-1:0] ofs_eff;

  always_comb begin
    buf_sel  = sel_rxq ? rxq_head : pkt_num;
    ofs_eff  = auto_inc ? ofs : ofs + {{(OFS_W-2){1'b0}}, lane};
    mem_addr = {buf_sel, ofs_eff};
  end
endmodule

// File: rtl/pbw_mem.sv
module pbw_mem #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    if (re) rdata <= cells[addr];
  end
endmodule

// File: rtl/pktbuf_window.sv
module pktbuf_window
  import pbw_pkg::*;
#(
  parameter int NUM_BUFS = 4,
  parameter int OFS_W    = 9,
  localparam int BUF_W   = $clog2(NUM_BUFS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [BUF_W-1:0] pkt_num,
  input  logic [BUF_W-1:0] rxq_head
);
  localparam int MEM_AW = BUF_W + OFS_W;

  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  pbw_acc_t          acc;
  logic [PTR_W-1:0]  ptr_q;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0]        mem_q;
  pbw_rsel_t         rsel_d, rsel_q;
  logic [7:0]        rbyte_d, rbyte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  pbw_decode u_dec (
    .addr (bus_addr),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .acc  (acc)
  );

  pbw_ptr #(.OFS_W(OFS_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .acc   (acc),
    .wdata (bus_wdata),
    .ptr_q (ptr_q)
  );

  pbw_addr_gen #(.OFS_W(OFS_W), .BUF_W(BUF_W)) u_agen (
    .sel_rxq  (ptr_q[SEL_BIT]),
    .auto_inc (ptr_q[INC_BIT]),
    .ofs      (ptr_q[OFS_W-1:0]),
    .lane     (bus_addr[1:0]),
    .pkt_num  (pkt_num),
    .rxq_head (rxq_head),
    .mem_addr (mem_addr)
  );

  pbw_mem #(.AW(MEM_AW)) u_mem (
    .clk   (clk),
    .we    (acc.dat_wr),
    .re    (acc.dat_rd),
    .addr  (mem_addr),
    .wdata (bus_wdata),
    .rdata (mem_q)
  );

  always_comb begin
    rsel_d  = RS_ZERO;
    rbyte_d = '0;
    if (acc.ptr_lo_rd) begin
      rsel_d  = RS_REG;
      rbyte_d = ptr_q[7:0];
    end else if (acc.ptr_hi_rd) begin
      rsel_d  = RS_REG;
      rbyte_d = ptr_q[15:8] & HI_RD_MASK;
    end else if (acc.dat_rd) begin
      rsel_d  = RS_MEM;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsel_q  <= RS_ZERO;
      rbyte_q <= '0;
    end else begin
      rsel_q  <= rsel_d;
      rbyte_q <= rbyte_d;
    end
  end

  always_comb begin
    unique case (rsel_q)
      RS_MEM:  bus_rdata = mem_q;
      RS_REG:  bus_rdata = rbyte_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pbw_checker.sv
module pbw_checker #(
  parameter int OFS_W = 9
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [7:0]  bus_rdata,
  input logic [15:0] ptr_q
);
  logic dat_acc;
  assign dat_acc = (bus_rd || bus_wr) && (bus_addr[3:2] == 2'b10);

  AST_RESET_PTR: assert property (@(posedge clk) !rst_n |-> ptr_q == 16'h0000); // R1

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R7

  AST_HI_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 4'd7) |=> bus_rdata[3] == 1'b0); // R3

  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && ptr_q[14]) |=>
      (ptr_q[OFS_W-1:0] == OFS_W'($past(ptr_q[OFS_W-1:0]) + 1'b1)) &&
      (ptr_q[15:OFS_W] == $past(ptr_q[15:OFS_W]))); // R5

  AST_DIRECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && !ptr_q[14]) |=> $stable(ptr_q)); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 8'h00); // R8
endmodule

bind pktbuf_window pbw_checker #(.OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .ptr_q     (ptr_q)
);

// File: tb/sim_pktbuf_window.sv
module sim_pktbuf_window;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 4;
  localparam int OW   = 9;
  localparam int BW   = 2;
  localparam int BUFB = 1 << OW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    bus_addr;
  logic          bus_rd, bus_wr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic [BW-1:0] pkt_num, rxq_head;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mdl_mem [NB*BUFB];
  logic [15:0] mdl_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pktbuf_window #(.NUM_BUFS(NB), .OFS_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pkt_num(pkt_num), .rxq_head(rxq_head)
  );

  function automatic int tgt_index(logic [1:0] lane);
    logic [BW-1:0] b;
    logic [OW-1:0] o;
    b = mdl_ptr[15] ? rxq_head : pkt_num;
    o = mdl_ptr[14] ? mdl_ptr[OW-1:0] : mdl_ptr[OW-1:0] + OW'(lane);
    return int'(b) * BUFB + int'(o);
  endfunction

  function automatic void mdl_step();
    if (mdl_ptr[14]) mdl_ptr[OW-1:0] = mdl_ptr[OW-1:0] + 1'b1;
  endfunction

  function automatic logic [7:0] exp_rd(logic [3:0] a);
    if (a == 4'd6) return mdl_ptr[7:0];
    if (a == 4'd7) return mdl_ptr[15:8] & 8'hF7;
    if (a[3:2] == 2'b10) return mdl_mem[tgt_index(a[1:0])];
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr8(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 4'd6) mdl_ptr[7:0] = d;
    else if (a == 4'd7) mdl_ptr[15:8] = d;
    else if (a[3:2] == 2'b10) begin
      mdl_mem[tgt_index(a[1:0])] = d;
      mdl_step();
    end
  endtask

  task automatic rd_chk(logic [3:0] a, string tag);
    logic [7:0] e;
    e = exp_rd(a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, e);
    if (a[3:2] == 2'b10) mdl_step();
  endtask

  task automatic set_ptr(logic [15:0] p);
    wr8(4'd6, p[7:0]);
    wr8(4'd7, p[15:8]);
  endtask

  task automatic burst_wr(int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      @(negedge clk);
      if (i > 0) mdl_step();
      bus_addr = 4'd8; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      mdl_mem[tgt_index(2'd0)] = d;
    end
    @(negedge clk);
    bus_wr = 1'b0;
    mdl_step();
  endtask

  task automatic burst_rd(int n, string tag);
    logic [7:0] e;
    @(negedge clk);
    bus_addr = 4'd8; bus_rd = 1'b1; bus_wr = 1'b0;
    for (int i = 0; i < n; i++) begin
      e = exp_rd(4'd8);
      @(negedge clk);
      if (i == n - 1) bus_rd = 1'b0;
      check(tag, bus_rdata, e);
      mdl_step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20117));
    bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    pkt_num = '0; rxq_head = '0; mdl_ptr = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 rdata in reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 8'h00);
    rd_chk(4'd6, "R1 ptr low after reset");
    rd_chk(4'd7, "R1 ptr high after reset");

    // R2/R3: byte-wise pointer load, high byte masked
    set_ptr(16'hABCD);
    rd_chk(4'd6, "R2 ptr low");
    rd_chk(4'd7, "R3 ptr high masked");
    wr8(4'd6, 8'h12);
    rd_chk(4'd7, "R2 high kept on low write");
    rd_chk(4'd6, "R2 low replaced");
    @(negedge clk);
    check("R8 idle rdata zero", bus_rdata, 8'h00);
    rd_chk(4'd3, "R8 unmapped read");
    rd_chk(4'd12, "R8 unmapped read high");

    // Preload every buffer through auto-increment bursts (R5, R7, R9)
    for (int b = 0; b < NB; b++) begin
      pkt_num = BW'(b);
      set_ptr(16'h4000);
      burst_wr(BUFB);
      rd_chk(4'd6, "R5 offset wrapped after full buffer");
    end

    // R9 back-to-back reads across a wrap, flags above the field set
    pkt_num = 2'd2;
    set_ptr(16'h49FC);
    burst_rd(6, "R9 back-to-back read");
    rd_chk(4'd6, "R5 low after wrap");
    rd_chk(4'd7, "R5 upper bits kept");

    // R5 single step at last offset with bits 15 and 11 set
    rxq_head = 2'd3; pkt_num = 2'd0;
    set_ptr(16'hC9FF);
    rd_chk(4'd8, "R4 R5 read at last offset");
    rd_chk(4'd6, "R5 wrap low");
    rd_chk(4'd7, "R5 wrap high masked");

    // R4 buffer select
    rxq_head = 2'd1; pkt_num = 2'd2;
    set_ptr(16'h0010);
    rd_chk(4'd8, "R4 packet-number buffer");
    set_ptr(16'h8010);
    rd_chk(4'd8, "R4 receive-head buffer");

    // R6 direct lanes including wrap, pointer untouched
    set_ptr(16'h01FE);
    for (int k = 0; k < 4; k++) rd_chk(4'(8 + k), "R6 direct lane read");
    wr8(4'd11, 8'h5A);
    rd_chk(4'd11, "R7 direct write readback");
    rd_chk(4'd6, "R6 pointer unchanged");

    // Random phase
    for (int n = 0; n < 500; n++) begin
      int op;
      pkt_num = BW'($urandom); rxq_head = BW'($urandom);
      op = int'($urandom % 7);
      case (op)
        0: wr8(4'd6, 8'($urandom));
        1: wr8(4'd7, 8'($urandom));
        2: wr8(4'(8 + $urandom % 4), 8'($urandom));
        3: rd_chk(4'(8 + $urandom % 4), "R4 R6 R7 random data read");
        4: rd_chk(4'(6 + $urandom % 2), "R3 random pointer read");
        5: rd_chk(4'($urandom % 6), "R8 random low address read");
        default: burst_rd(3, "R9 random burst");
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule